// File: doc/BRIEF.md
# Extended Pointer Address Unit

This unit keeps the three data pointers of a small microcontroller core as whole 24-bit values. Each pointer joins an 8-bit page byte to a 16-bit register pair: X is page X with R27:R26, Y is page Y with R29:R28, and Z is page Z with R31:R30. In every case the page byte is the most significant byte. The ALU writes single bytes of these registers, and the unit folds each byte straight into the stored pointer. A matching select code reads any byte back.

On a memory access the unit returns the selected pointer as a data address. In the post-increment and pre-decrement modes it also writes back the pointer plus or minus one across all 24 bits. It forms indirect jump targets from R31:R30, either zero-extended to 24 bits or topped with a separate jump extension byte.

For the two read-modify-write operations, load-and-clear and exchange, the unit runs a two-cycle read-then-write sequence at the Z address. It raises a busy output while the sequence runs and computes the byte written back.

Top module: `ptr_unit`

## Requirements
- R1: After reset, every pointer byte, page byte and the jump extension byte read as 0, and `busy`, `memRd`, `memWr` and `xchgWe` are 0.
- R2: When `wrEn` is 1, the byte selected by `wrSel` takes `wrData` at the clock edge. The select codes are: 0 = R26, 1 = R27, 2 = R28, 3 = R29, 4 = R30, 5 = R31, 6 = page X, 7 = page Y, 8 = page Z, 9 = jump extension. `rdData` shows the byte chosen by `rdSel`, which uses the same codes, with no added latency. Codes 10 to 15 write nothing and read 0.
- R3: While idle, with `accMode` = 0 (plain) or 3, `memAddr` equals the pointer chosen by `accPtr` (0 = X, 1 = Y, 2 = Z), built as {page, high, low}, and the pointer is not changed. `accPtr` = 3 gives address 0 and changes nothing.
- R4: With `accEn` = 1 and `accMode` = 1 (post-increment), `memAddr` is the current pointer. The pointer becomes pointer+1 modulo 2^24, so a carry from the high byte reaches the page byte and 0xFFFFFF wraps to 0.
- R5: With `accEn` = 1 and `accMode` = 2 (pre-decrement), `memAddr` is pointer-1 in that same cycle, and the pointer becomes pointer-1 modulo 2^24, borrowing from the page byte.
- R6: If a byte write and an auto-modify hit the same pointer in one cycle, the written byte replaces that byte of the modified value. The other two bytes keep the modified value.
- R7: `jmpTarget` is {0, R31, R30} when `jmpExt` = 0 and {jump extension, R31, R30} when `jmpExt` = 1. Page Z never enters it.
- R8: `rmwStart` accepted while idle gives, over the next two cycles, one read cycle (`busy` = 1, `memRd` = 1, `memAddr` = Z) and then one write cycle (`busy` = 1, `memWr` = 1, same address). After that the unit is idle again.
- R9: Load-and-clear (`rmwOp` = 0) writes `memRdata` & ~operand in the write cycle. The operand is `rmwReg` captured at start. `xchgWe` stays 0.
- R10: Exchange (`rmwOp` = 1) writes the captured operand in the write cycle, and drives `xchgData` = `memRdata` with `xchgWe` = 1 in that cycle.
- R11: A read-modify-write sequence leaves Z unchanged. While `busy` = 1, `accEn` and `rmwStart` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Byte write strobe from the ALU |
| wrSel | input | 4 | Byte select code for writes |
| wrData | input | 8 | Byte to write |
| rdSel | input | 4 | Byte select code for reads |
| rdData | output | 8 | Selected byte |
| accEn | input | 1 | Data access request |
| accPtr | input | 2 | Pointer choice: 0 X, 1 Y, 2 Z |
| accMode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 plain |
| memAddr | output | 24 | Data address |
| jmpExt | input | 1 | Use the extension byte for the jump target |
| jmpTarget | output | 24 | Indirect jump target |
| rmwStart | input | 1 | Start a read-modify-write sequence |
| rmwOp | input | 1 | 0 load-and-clear, 1 exchange |
| rmwReg | input | 8 | Register operand of the sequence |
| memRdata | input | 8 | Memory read data, valid in the write cycle |
| busy | output | 1 | Sequence in progress |
| memRd | output | 1 | Read strobe of the sequence |
| memWr | output | 1 | Write strobe of the sequence |
| memWdata | output | 8 | Byte written back |
| xchgData | output | 8 | Old memory byte for the register file |
| xchgWe | output | 1 | Register write strobe for exchange |

## Verification
The assertions check the sequence shape on every cycle: a read cycle is always followed by a write cycle, and the unit always goes idle after the write. The write keeps the read address unless a byte write intervened. The jump target's top byte is zero when no extension is asked for, and the exchange strobe never appears outside a write cycle.

Some behaviour needs known stored values, so only the bench scenarios show it. This covers the arithmetic of post-increment and pre-decrement across byte and page boundaries, including wrap-around. It also covers the byte-override priority, the written data for each operation, and the fact that accesses and starts made while busy leave the pointers untouched.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  localparam int PTR_N = 3;
  localparam int SEL_W = 4;
  localparam int PTR_Z = 2;
  localparam int SEL_PAGE0 = 6;
  localparam int SEL_EXT = 9;

  typedef enum logic [1:0] {AM_PLAIN = 2'd0, AM_POSTINC = 2'd1, AM_PREDEC = 2'd2, AM_SPARE = 2'd3} accMode_e;

  typedef struct packed {
    logic useZ;
    logic memRd;
    logic memWr;
    logic capture;
    logic isXchg;
  } ptrStrobe_t;
endpackage

// File: rtl/ptr_ctrl.sv
module ptr_ctrl
  import ptr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rmwStart,
  input  logic       rmwOp,
  output ptrStrobe_t strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} rmwState_e;
  rmwState_e stateQ;
  logic      opQ;
  logic      startOk;

  assign startOk = (stateQ == ST_IDLE) && rmwStart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      opQ    <= 1'b0;
    end else begin
      unique case (stateQ)
        ST_IDLE:  if (rmwStart) stateQ <= ST_READ;
        ST_READ:  stateQ <= ST_WRITE;
        default:  stateQ <= ST_IDLE;
      endcase
      if (startOk) opQ <= rmwOp;
    end
  end

  always_comb begin
    strb.useZ    = (stateQ != ST_IDLE);
    strb.memRd   = (stateQ == ST_READ);
    strb.memWr   = (stateQ == ST_WRITE);
    strb.capture = startOk;
    strb.isXchg  = opQ;
  end
endmodule

// File: rtl/ptr_dpath.sv
module ptr_dpath
  import ptr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ptrStrobe_t          strb,
  input  logic                wrEn,
  input  logic [SEL_W-1:0]    wrSel,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic [SEL_W-1:0]    rdSel,
  output logic [BYTE_W-1:0]   rdData,
  input  logic                accEn,
  input  logic [1:0]          accPtr,
  input  logic [1:0]          accMode,
  output logic [3*BYTE_W-1:0] memAddr,
  input  logic                jmpExt,
  output logic [3*BYTE_W-1:0] jmpTarget,
  input  logic [BYTE_W-1:0]   rmwReg,
  input  logic [BYTE_W-1:0]   memRdata,
  output logic [BYTE_W-1:0]   memWdata,
  output logic [BYTE_W-1:0]   xchgData
);
  localparam int ADDR_W = 3 * BYTE_W;
  localparam int LO_W   = 2 * BYTE_W;

  logic [ADDR_W-1:0] ptrQ   [PTR_N];
  logic [ADDR_W-1:0] ptrNxt [PTR_N];
  logic [BYTE_W-1:0] extQ;
  logic [BYTE_W-1:0] operandQ;
  logic [ADDR_W-1:0] selPtr;

  for (genvar p = 0; p < PTR_N; p++) begin : g_ptr
    logic hitMod;
    assign hitMod = accEn && !strb.useZ && (accPtr == 2'(p)) &&
                    ((accMode == AM_POSTINC) || (accMode == AM_PREDEC));
    always_comb begin
      ptrNxt[p] = ptrQ[p];
      if (hitMod) ptrNxt[p] = (accMode == AM_POSTINC) ? ptrQ[p] + 1'b1 : ptrQ[p] - 1'b1;
      if (wrEn) begin
        if (wrSel == SEL_W'(2 * p))         ptrNxt[p][BYTE_W-1:0]      = wrData;
        if (wrSel == SEL_W'(2 * p + 1))     ptrNxt[p][LO_W-1:BYTE_W]   = wrData;
        if (wrSel == SEL_W'(SEL_PAGE0 + p)) ptrNxt[p][ADDR_W-1:LO_W]   = wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < PTR_N; p++) ptrQ[p] <= '0;
      extQ     <= '0;
      operandQ <= '0;
    end else begin
      for (int p = 0; p < PTR_N; p++) ptrQ[p] <= ptrNxt[p];
      if (wrEn && (wrSel == SEL_W'(SEL_EXT))) extQ <= wrData;
      if (strb.capture) operandQ <= rmwReg;
    end
  end

  always_comb begin
    rdData = '0;
    for (int p = 0; p < PTR_N; p++) begin
      if (rdSel == SEL_W'(2 * p))         rdData = ptrQ[p][BYTE_W-1:0];
      if (rdSel == SEL_W'(2 * p + 1))     rdData = ptrQ[p][LO_W-1:BYTE_W];
      if (rdSel == SEL_W'(SEL_PAGE0 + p)) rdData = ptrQ[p][ADDR_W-1:LO_W];
    end
    if (rdSel == SEL_W'(SEL_EXT)) rdData = extQ;
  end

  always_comb begin
    selPtr = '0;
    for (int p = 0; p < PTR_N; p++)
      if (accPtr == 2'(p)) selPtr = ptrQ[p];
    if (strb.useZ)                  memAddr = ptrQ[PTR_Z];
    else if (accMode == AM_PREDEC)  memAddr = selPtr - 1'b1;
    else                            memAddr = selPtr;
  end

  assign jmpTarget = {(jmpExt ? extQ : {BYTE_W{1'b0}}), ptrQ[PTR_Z][LO_W-1:0]};
  assign memWdata  = strb.isXchg ? operandQ : (memRdata & ~operandQ);
  assign xchgData  = memRdata;
endmodule

// File: rtl/ptr_unit.sv
module ptr_unit
  import ptr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [3:0]          wrSel,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic [3:0]          rdSel,
  output logic [BYTE_W-1:0]   rdData,
  input  logic                accEn,
  input  logic [1:0]          accPtr,
  input  logic [1:0]          accMode,
  output logic [3*BYTE_W-1:0] memAddr,
  input  logic                jmpExt,
  output logic [3*BYTE_W-1:0] jmpTarget,
  input  logic                rmwStart,
  input  logic                rmwOp,
  input  logic [BYTE_W-1:0]   rmwReg,
  input  logic [BYTE_W-1:0]   memRdata,
  output logic                busy,
  output logic                memRd,
  output logic                memWr,
  output logic [BYTE_W-1:0]   memWdata,
  output logic [BYTE_W-1:0]   xchgData,
  output logic                xchgWe
);
  ptrStrobe_t strb;

  ptr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rmwStart(rmwStart), .rmwOp(rmwOp), .strb(strb)
  );

  ptr_dpath #(.BYTE_W(BYTE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData),
    .accEn(accEn), .accPtr(accPtr), .accMode(accMode), .memAddr(memAddr),
    .jmpExt(jmpExt), .jmpTarget(jmpTarget),
    .rmwReg(rmwReg), .memRdata(memRdata), .memWdata(memWdata), .xchgData(xchgData)
  );

  assign busy   = strb.useZ;
  assign memRd  = strb.memRd;
  assign memWr  = strb.memWr;
  assign xchgWe = strb.memWr && strb.isXchg;
endmodule

// File: rtl/ptr_unit_chk.sv
module ptr_unit_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic                jmpExt,
  input logic [3*BYTE_W-1:0] memAddr,
  input logic [3*BYTE_W-1:0] jmpTarget,
  input logic                busy,
  input logic                memRd,
  input logic                memWr,
  input logic                xchgWe
);
  // R8: read cycle is always followed by the write cycle
  a_r8_read_then_write: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> memWr && busy);

  // R8, R11: sequence ends after the write, no restart while busy
  a_r8_idle_after_write: assert property (@(posedge clk) disable iff (!rstN)
    memWr |=> !busy);

  // R8: strobes are exclusive and only appear while busy
  a_r8_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) |-> (busy && !(memRd && memWr)));

  // R11: write goes to the read address when no byte write intervened
  a_r11_same_addr: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && !$past(wrEn)) |-> (memAddr == $past(memAddr)));

  // R7: no extension requested means a zero top byte
  a_r7_no_ext: assert property (@(posedge clk) disable iff (!rstN)
    !jmpExt |-> (jmpTarget[3*BYTE_W-1:2*BYTE_W] == '0));

  // R10: register strobe only in the write cycle
  a_r10_xchg_in_write: assert property (@(posedge clk) disable iff (!rstN)
    xchgWe |-> memWr);
endmodule

bind ptr_unit ptr_unit_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .jmpExt(jmpExt), .memAddr(memAddr),
  .jmpTarget(jmpTarget), .busy(busy), .memRd(memRd), .memWr(memWr), .xchgWe(xchgWe)
);

// File: tb/sim_ptr_unit.sv
`timescale 1ns/1ps
module sim_ptr_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrSel = '0;
  logic [7:0] wrData = '0;
  logic [3:0] rdSel = '0;
  logic [7:0] rdData;
  logic accEn = 1'b0;
  logic [1:0] accPtr = '0;
  logic [1:0] accMode = '0;
  logic [23:0] memAddr;
  logic jmpExt = 1'b0;
  logic [23:0] jmpTarget;
  logic rmwStart = 1'b0;
  logic rmwOp = 1'b0;
  logic [7:0] rmwReg = '0;
  logic [7:0] memRdata = '0;
  logic busy, memRd, memWr, xchgWe;
  logic [7:0] memWdata, xchgData;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ptr_unit u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .accEn(accEn), .accPtr(accPtr), .accMode(accMode),
    .memAddr(memAddr), .jmpExt(jmpExt), .jmpTarget(jmpTarget), .rmwStart(rmwStart),
    .rmwOp(rmwOp), .rmwReg(rmwReg), .memRdata(memRdata), .busy(busy), .memRd(memRd),
    .memWr(memWr), .memWdata(memWdata), .xchgData(xchgData), .xchgWe(xchgWe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeByte(input logic [3:0] sel, input logic [7:0] val);
    wrEn = 1'b1; wrSel = sel; wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setPtr(input int p, input logic [23:0] val);
    writeByte(4'(2 * p), val[7:0]);
    writeByte(4'(2 * p + 1), val[15:8]);
    writeByte(4'(6 + p), val[23:16]);
  endtask

  function automatic logic [23:0] peekAddr(input int p);
    accPtr = 2'(p); accMode = 2'd0;
    return 24'(0);
  endfunction

  task automatic checkPtr(input string req, input int p, input logic [23:0] exp);
    logic [23:0] got;
    rdSel = 4'(2 * p);     #1 got[7:0]   = rdData;
    rdSel = 4'(2 * p + 1); #1 got[15:8]  = rdData;
    rdSel = 4'(6 + p);     #1 got[23:16] = rdData;
    check(req, 32'(got), 32'(exp));
  endtask

  task automatic t_reset();
    for (int s = 0; s < 10; s++) begin
      rdSel = 4'(s); #1;
      check("R1 reset byte", 32'(rdData), 32'h0);
    end
    check("R1 reset strobes", {28'h0, busy, memRd, memWr, xchgWe}, 32'h0);
  endtask

  task automatic t_bytes();
    setPtr(0, 24'h123456);
    setPtr(1, 24'hABCDEF);
    setPtr(2, 24'h7A8B9C);
    writeByte(4'd9, 8'h3C);
    writeByte(4'd12, 8'hEE);
    checkPtr("R2 X bytes", 0, 24'h123456);
    checkPtr("R2 Y bytes", 1, 24'hABCDEF);
    checkPtr("R2 Z bytes", 2, 24'h7A8B9C);
    rdSel = 4'd9; #1 check("R2 ext byte", 32'(rdData), 32'h3C);
    rdSel = 4'd12; #1 check("R2 unused code", 32'(rdData), 32'h0);
  endtask

  task automatic t_plain();
    accEn = 1'b1; accMode = 2'd0;
    for (int p = 0; p < 3; p++) begin
      accPtr = 2'(p); #1;
      check("R3 plain address", 32'(memAddr),
            p == 0 ? 32'h123456 : (p == 1 ? 32'hABCDEF : 32'h7A8B9C));
    end
    accPtr = 2'd3; #1 check("R3 no pointer", 32'(memAddr), 32'h0);
    accPtr = 2'd1; accMode = 2'd3;
    @(negedge clk);
    accEn = 1'b0; accMode = 2'd0;
    checkPtr("R3 unchanged", 1, 24'hABCDEF);
  endtask

  task automatic t_postinc();
    setPtr(0, 24'h00FFFF);
    accEn = 1'b1; accPtr = 2'd0; accMode = 2'd1; #1;
    check("R4 address is old", 32'(memAddr), 32'h00FFFF);
    @(negedge clk);
    accEn = 1'b0; accMode = 2'd0;
    checkPtr("R4 carry into page", 0, 24'h010000);
    setPtr(2, 24'hFFFFFF);
    accEn = 1'b1; accPtr = 2'd2; accMode = 2'd1;
    @(negedge clk);
    accEn = 1'b0; accMode = 2'd0;
    checkPtr("R4 wrap", 2, 24'h000000);
  endtask

  task automatic t_predec();
    setPtr(1, 24'h050000);
    accEn = 1'b1; accPtr = 2'd1; accMode = 2'd2; #1;
    check("R5 address is new", 32'(memAddr), 32'h04FFFF);
    @(negedge clk);
    accEn = 1'b0; accMode = 2'd0;
    checkPtr("R5 borrow from page", 1, 24'h04FFFF);
    setPtr(0, 24'h000000);
    accEn = 1'b1; accPtr = 2'd0; accMode = 2'd2;
    @(negedge clk);
    accEn = 1'b0; accMode = 2'd0;
    checkPtr("R5 wrap", 0, 24'hFFFFFF);
  endtask

  task automatic t_override();
    setPtr(1, 24'h0000FF);
    accEn = 1'b1; accPtr = 2'd1; accMode = 2'd1;
    wrEn = 1'b1; wrSel = 4'd2; wrData = 8'h55;
    @(negedge clk);
    accEn = 1'b0; accMode = 2'd0; wrEn = 1'b0;
    checkPtr("R6 byte overrides increment", 1, 24'h000155);
  endtask

  task automatic t_jump();
    setPtr(2, 24'h9A1234);
    writeByte(4'd9, 8'h42);
    jmpExt = 1'b0; #1 check("R7 plain jump", 32'(jmpTarget), 32'h001234);
    jmpExt = 1'b1; #1 check("R7 extended jump", 32'(jmpTarget), 32'h421234);
    jmpExt = 1'b0;
  endtask

  task automatic t_rmw(input logic op, input logic [7:0] reg8, input logic [7:0] mem8);
    setPtr(2, 24'h02A0B0);
    setPtr(0, 24'h001000);
    rmwStart = 1'b1; rmwOp = op; rmwReg = reg8;
    @(negedge clk);
    rmwStart = 1'b0; rmwReg = 8'h00;
    check("R8 read cycle", {28'h0, busy, memRd, memWr, xchgWe}, 32'hC);
    check("R8 read address", 32'(memAddr), 32'h02A0B0);
    memRdata = mem8;
    accEn = 1'b1; accPtr = 2'd0; accMode = 2'd1;
    @(negedge clk);
    accEn = 1'b0; accMode = 2'd0;
    rmwStart = 1'b1; rmwOp = ~op;
    check("R8 write cycle", {28'h0, busy, memRd, memWr, 1'b0}, 32'hA);
    check("R8 write address", 32'(memAddr), 32'h02A0B0);
    if (op) begin
      check("R10 exchange write data", 32'(memWdata), 32'(reg8));
      check("R10 exchange register data", {23'h0, xchgWe, xchgData}, {23'h0, 1'b1, mem8});
    end else begin
      check("R9 clear write data", 32'(memWdata), 32'(mem8 & ~reg8));
      check("R9 no register write", 32'(xchgWe), 32'h0);
    end
    @(negedge clk);
    rmwStart = 1'b0;
    check("R11 idle after sequence", {28'h0, busy, memRd, memWr, xchgWe}, 32'h0);
    checkPtr("R11 Z unchanged", 2, 24'h02A0B0);
    checkPtr("R11 access while busy ignored", 0, 24'h001000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_bytes();
    t_plain();
    t_postinc();
    t_predec();
    t_override();
    t_jump();
    t_rmw(1'b0, 8'h0F, 8'hF3);
    t_rmw(1'b1, 8'h5A, 8'hC7);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end
endmodule